// File: doc/BRIEF.md
# Block-granular address router

This block sits between a processor's memory access path and the memory-mapped resources of a system. It routes every access in the 32-bit physical space to one of three destinations: the RAM port, one of several device slots, or a built-in sink for unmapped space. Routing works in 16 KiB blocks. A device region covers a whole number of blocks. Each region is registered through a small configuration port, together with the access width its handler accepts: byte-only or dword-capable.

A device sees offsets relative to the start of its own region, never absolute addresses. A dword access to a byte-only region is broken into four byte accesses at consecutive offsets, and the read bytes are reassembled in little-endian order. Addresses below the installed RAM size (the `RAM_BYTES` parameter, which must be a multiple of 16 KiB) that no region covers go to RAM unchanged. Everything at or above that size that no region covers reads as all-ones bytes, and writes there are dropped. When regions overlap, the most recent registration decides the route.

Downstream ports answer combinationally in the cycle they are strobed. The requester holds `req_valid` and its fields steady until it sees `req_ready`.

Top module: `blkmap_router`

## Requirements
- R1: A registration is rejected, and leaves every route unchanged, if its base is not a multiple of 16 KiB, its size is zero or not a multiple of 16 KiB, its base plus size exceeds 2^32, or its slot number is out of range.
- R2: A device access carries the offset of the access address from its region base on `dev_off`. Exactly one bit of `dev_en` is high: bit s for slot s.
- R3: Where registered regions overlap, the one accepted most recently owns the address. Registering a slot again replaces that slot's previous region.
- R4: An address below `RAM_BYTES` that no region covers produces one RAM access carrying the absolute address. A dword request reaches RAM as a single dword access.
- R5: An address at or above `RAM_BYTES` that no region covers strobes no port. A byte read there returns 0x000000FF, a dword read returns 0xFFFFFFFF, and a write has no effect.
- R6: A dword request to a dword-capable region produces one dword access (`dev_dword`=1) with the full write data.
- R7: A dword read to a byte-only region (`cfg_wide`=0) produces four byte reads at offsets off, off+1, off+2 and off+3 on consecutive cycles. Each device returns its byte in bits 7:0, and byte i lands in `req_rdata` bits 8i+7:8i.
- R8: A dword write to a byte-only region produces four byte writes. Beat i carries `req_wdata` bits 8i+7:8i in `wdata` bits 7:0, with bits 31:8 zero.
- R9: A byte request (`req_dword`=0) produces exactly one byte access with `req_wdata[7:0]`. A byte read returns the byte in `req_rdata[7:0]`, with bits 31:8 zero.
- R10: A request is accepted at a clock edge where the block is idle. Its beats appear one per cycle starting in the next cycle. `req_ready` is high for exactly one cycle, the cycle after the last beat, and `req_rdata` is valid in that cycle. Unmapped beats take the same number of cycles but strobe nothing.
- R11: At most one of `ram_en` and the `dev_en` bits is high in any cycle.
- R12: After reset, `req_ready`, `ram_en` and `dev_en` are low and no region is registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Registration strobe |
| cfg_slot | input | SW | Slot being registered |
| cfg_base | input | 32 | Region base address |
| cfg_size | input | 32 | Region size in bytes |
| cfg_wide | input | 1 | 1: handler takes dword accesses; 0: byte only |
| req_valid | input | 1 | Access request, held until ready |
| req_addr | input | 32 | Access address |
| req_dword | input | 1 | 1: dword access; 0: byte access |
| req_write | input | 1 | 1: write; 0: read |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Read result, valid with req_ready |
| ram_en | output | 1 | RAM access strobe |
| ram_addr | output | 32 | RAM address |
| ram_dword | output | 1 | RAM access is a dword |
| ram_we | output | 1 | RAM write |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data |
| dev_en | output | NUM_SLOTS | Per-slot device strobe |
| dev_off | output | 32 | Region-relative offset |
| dev_dword | output | 1 | Device access is a dword |
| dev_we | output | 1 | Device write |
| dev_wdata | output | 32 | Device write data |
| dev_rdata | input | NUM_SLOTS x 32 | Per-slot device read data |

## Verification
The hardest cases to reach are those where the route depends on registration history rather than on the current address. These include a later region shadowing part of an earlier one, re-registering a slot, which must release its old range back to RAM or to the unmapped sink, and malformed registrations that must leave the table untouched. The stimulus covers these with a fixed sequence of configurations. After each one, it probes addresses on both sides of every boundary involved. It then runs randomly chosen requests over the resulting map. The bench model tracks registrations with a separate age counter and checks every strobed cycle of every split access.

// File: rtl/blkmap_pkg.sv
package blkmap_pkg;

    localparam int unsigned AW = 32;
    localparam int unsigned DW = 32;

    typedef enum logic [1:0] {
        KIND_RAM  = 2'd0,
        KIND_DEV  = 2'd1,
        KIND_VOID = 2'd2
    } kind_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_BEAT = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    // One registered window; limit is one past the last byte (33 bits).
    typedef struct packed {
        logic          live;
        logic          wide;
        logic [AW-1:0] base;
        logic [AW:0]   limit;
    } region_t;

    // Destination chosen for a request at the moment it is accepted.
    typedef struct packed {
        kind_e         kind;
        logic          wide;
        logic [AW-1:0] offset;
    } route_t;

    function automatic logic is_aligned(input logic [AW-1:0] v, input int unsigned sh);
        logic [AW-1:0] m;
        m = (32'(1) << sh) - 32'(1);
        return (v & m) == '0;
    endfunction

    function automatic logic [DW-1:0] byte_lane(input logic [DW-1:0] w, input logic [1:0] idx);
        return {24'h0, w[{idx, 3'b000} +: 8]};
    endfunction

endpackage

// File: rtl/blkmap_table.sv
module blkmap_table
    import blkmap_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 4,
    parameter int unsigned BLK_SHIFT = 14,
    localparam int unsigned SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_valid,
    input  logic [SW-1:0] cfg_slot,
    input  logic [AW-1:0] cfg_base,
    input  logic [AW-1:0] cfg_size,
    input  logic          cfg_wide,
    input  logic [AW-1:0] look_addr,
    output logic          look_hit,
    output logic [SW-1:0] look_slot,
    output logic          look_wide,
    output logic [AW-1:0] look_base
);

    localparam logic [SW-1:0] TOP_RANK = SW'(NUM_SLOTS - 1);
    localparam logic [AW:0]   SPACE_END = {1'b1, {AW{1'b0}}};

    region_t       tab_q  [NUM_SLOTS];
    logic [SW-1:0] rank_q [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] match;
    logic          cfg_ok;
    logic [AW:0]   cfg_limit;
    logic [SW-1:0] best_rank;

    assign cfg_limit = {1'b0, cfg_base} + {1'b0, cfg_size};
    assign cfg_ok = cfg_valid
                 && (32'(cfg_slot) < NUM_SLOTS)
                 && is_aligned(cfg_base, BLK_SHIFT)
                 && is_aligned(cfg_size, BLK_SHIFT)
                 && (cfg_size != '0)
                 && (cfg_limit <= SPACE_END);

    // Ranks form a permutation; the accepted slot takes the top rank and
    // every slot that stood above it moves down one place.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SLOTS; s++) begin
                tab_q[s]  <= '0;
                rank_q[s] <= SW'(s);
            end
        end else if (cfg_ok) begin
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (SW'(s) == cfg_slot) begin
                    tab_q[s]  <= '{live: 1'b1, wide: cfg_wide, base: cfg_base, limit: cfg_limit};
                    rank_q[s] <= TOP_RANK;
                end else if (rank_q[s] > rank_q[cfg_slot]) begin
                    rank_q[s] <= rank_q[s] - SW'(1);
                end
            end
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_match
        assign match[g] = tab_q[g].live
                       && ({1'b0, look_addr} >= {1'b0, tab_q[g].base})
                       && ({1'b0, look_addr} <  tab_q[g].limit);
    end

    always_comb begin
        look_hit  = 1'b0;
        look_slot = '0;
        best_rank = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (match[s] && (!look_hit || rank_q[s] > best_rank)) begin
                look_hit  = 1'b1;
                look_slot = SW'(s);
                best_rank = rank_q[s];
            end
        end
    end

    assign look_wide = tab_q[look_slot].wide;
    assign look_base = tab_q[look_slot].base;

endmodule

// File: rtl/blkmap_seq.sv
module blkmap_seq
    import blkmap_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 4,
    localparam int unsigned SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic                          req_dword,
    input  logic [DW-1:0]                 req_wdata,
    input  route_t                        route_in,
    input  logic [SW-1:0]                 slot_in,
    output logic                          req_ready,
    output logic [DW-1:0]                 req_rdata,
    output logic                          ram_en,
    output logic [AW-1:0]                 ram_addr,
    output logic                          ram_dword,
    output logic                          ram_we,
    output logic [DW-1:0]                 ram_wdata,
    input  logic [DW-1:0]                 ram_rdata,
    output logic [NUM_SLOTS-1:0]          dev_en,
    output logic [AW-1:0]                 dev_off,
    output logic                          dev_dword,
    output logic                          dev_we,
    output logic [DW-1:0]                 dev_wdata,
    input  logic [NUM_SLOTS-1:0][DW-1:0]  dev_rdata
);

    phase_e        phase_q;
    route_t        rt_q;
    logic [SW-1:0] slot_q;
    logic          we_q;
    logic          dword_q;
    logic [DW-1:0] wdata_q;
    logic [1:0]    beat_q;
    logic [DW-1:0] acc_q;

    logic          whole;
    logic [1:0]    last_beat;
    logic          active;
    logic [AW-1:0] bus_addr;
    logic          bus_dword;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] src;

    assign whole     = !dword_q || rt_q.wide;
    assign last_beat = whole ? 2'd0 : 2'd3;
    assign active    = (phase_q == PH_BEAT);
    assign bus_addr  = rt_q.offset + {{(AW-2){1'b0}}, beat_q};
    assign bus_dword = dword_q && rt_q.wide;
    assign bus_wdata = bus_dword ? wdata_q : byte_lane(wdata_q, beat_q);

    always_comb begin
        case (rt_q.kind)
            KIND_RAM: src = ram_rdata;
            KIND_DEV: src = dev_rdata[slot_q];
            default:  src = {DW{1'b1}};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            rt_q    <= '{kind: KIND_VOID, wide: 1'b0, offset: '0};
            slot_q  <= '0;
            we_q    <= 1'b0;
            dword_q <= 1'b0;
            wdata_q <= '0;
            beat_q  <= '0;
            acc_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (req_valid) begin
                        rt_q    <= route_in;
                        slot_q  <= slot_in;
                        we_q    <= req_write;
                        dword_q <= req_dword;
                        wdata_q <= req_wdata;
                        beat_q  <= '0;
                        acc_q   <= '0;
                        phase_q <= PH_BEAT;
                    end
                end
                PH_BEAT: begin
                    if (!we_q) begin
                        if (bus_dword) acc_q <= src;
                        else           acc_q[{beat_q, 3'b000} +: 8] <= src[7:0];
                    end
                    if (beat_q == last_beat) phase_q <= PH_DONE;
                    else                     beat_q  <= beat_q + 2'd1;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign req_ready = (phase_q == PH_DONE);
    assign req_rdata = acc_q;

    assign ram_en    = active && (rt_q.kind == KIND_RAM);
    assign ram_addr  = bus_addr;
    assign ram_dword = bus_dword;
    assign ram_we    = we_q;
    assign ram_wdata = bus_wdata;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_dev_en
        assign dev_en[g] = active && (rt_q.kind == KIND_DEV) && (slot_q == SW'(g));
    end
    assign dev_off   = bus_addr;
    assign dev_dword = bus_dword;
    assign dev_we    = we_q;
    assign dev_wdata = bus_wdata;

endmodule

// File: rtl/blkmap_router.sv
module blkmap_router
    import blkmap_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 4,
    parameter int unsigned BLK_SHIFT = 14,
    parameter logic [31:0] RAM_BYTES = 32'h0100_0000,
    localparam int unsigned SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_valid,
    input  logic [SW-1:0]                 cfg_slot,
    input  logic [31:0]                   cfg_base,
    input  logic [31:0]                   cfg_size,
    input  logic                          cfg_wide,
    input  logic                          req_valid,
    input  logic [31:0]                   req_addr,
    input  logic                          req_dword,
    input  logic                          req_write,
    input  logic [31:0]                   req_wdata,
    output logic                          req_ready,
    output logic [31:0]                   req_rdata,
    output logic                          ram_en,
    output logic [31:0]                   ram_addr,
    output logic                          ram_dword,
    output logic                          ram_we,
    output logic [31:0]                   ram_wdata,
    input  logic [31:0]                   ram_rdata,
    output logic [NUM_SLOTS-1:0]          dev_en,
    output logic [31:0]                   dev_off,
    output logic                          dev_dword,
    output logic                          dev_we,
    output logic [31:0]                   dev_wdata,
    input  logic [NUM_SLOTS-1:0][31:0]    dev_rdata
);

    logic          look_hit;
    logic [SW-1:0] look_slot;
    logic          look_wide;
    logic [AW-1:0] look_base;
    route_t        route;

    blkmap_table #(
        .NUM_SLOTS (NUM_SLOTS),
        .BLK_SHIFT (BLK_SHIFT)
    ) u_table (
        .clk       (clk),
        .rst       (rst),
        .cfg_valid (cfg_valid),
        .cfg_slot  (cfg_slot),
        .cfg_base  (cfg_base),
        .cfg_size  (cfg_size),
        .cfg_wide  (cfg_wide),
        .look_addr (req_addr),
        .look_hit  (look_hit),
        .look_slot (look_slot),
        .look_wide (look_wide),
        .look_base (look_base)
    );

    // Registered regions override both RAM and the unmapped default.
    always_comb begin
        if (look_hit) begin
            route = '{kind: KIND_DEV, wide: look_wide, offset: req_addr - look_base};
        end else if (req_addr < RAM_BYTES) begin
            route = '{kind: KIND_RAM, wide: 1'b1, offset: req_addr};
        end else begin
            route = '{kind: KIND_VOID, wide: 1'b0, offset: req_addr - RAM_BYTES};
        end
    end

    blkmap_seq #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_dword (req_dword),
        .req_wdata (req_wdata),
        .route_in  (route),
        .slot_in   (look_slot),
        .req_ready (req_ready),
        .req_rdata (req_rdata),
        .ram_en    (ram_en),
        .ram_addr  (ram_addr),
        .ram_dword (ram_dword),
        .ram_we    (ram_we),
        .ram_wdata (ram_wdata),
        .ram_rdata (ram_rdata),
        .dev_en    (dev_en),
        .dev_off   (dev_off),
        .dev_dword (dev_dword),
        .dev_we    (dev_we),
        .dev_wdata (dev_wdata),
        .dev_rdata (dev_rdata)
    );

endmodule

// File: rtl/blkmap_router_chk.sv
module blkmap_router_chk #(
    parameter int unsigned NUM_SLOTS = 4,
    parameter logic [31:0] RAM_BYTES = 32'h0100_0000
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 ram_en,
    input logic [31:0]          ram_addr,
    input logic                 ram_dword,
    input logic                 ram_we,
    input logic [31:0]          ram_wdata,
    input logic [NUM_SLOTS-1:0] dev_en,
    input logic [31:0]          dev_off,
    input logic                 dev_dword,
    input logic                 dev_we,
    input logic [31:0]          dev_wdata
);

    p_ready_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> !req_ready);

    p_ready_after_req_r10: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> $past(req_valid));

    p_quiet_at_ready_r10: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!ram_en && dev_en == '0));

    p_single_target_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ram_en, dev_en}));

    p_ram_window_r4: assert property (@(posedge clk) disable iff (rst)
        ram_en |-> (ram_addr < RAM_BYTES));

    p_dev_step_r7: assert property (@(posedge clk) disable iff (rst)
        (dev_en != '0 && !dev_dword && $past(dev_en) == dev_en)
        |-> dev_off == $past(dev_off) + 32'd1);

    p_dev_byte_lane_r8: assert property (@(posedge clk) disable iff (rst)
        (dev_en != '0 && dev_we && !dev_dword) |-> dev_wdata[31:8] == 24'h0);

    p_ram_byte_lane_r9: assert property (@(posedge clk) disable iff (rst)
        (ram_en && ram_we && !ram_dword) |-> ram_wdata[31:8] == 24'h0);

endmodule

bind blkmap_router blkmap_router_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .RAM_BYTES (RAM_BYTES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .ram_en    (ram_en),
    .ram_addr  (ram_addr),
    .ram_dword (ram_dword),
    .ram_we    (ram_we),
    .ram_wdata (ram_wdata),
    .dev_en    (dev_en),
    .dev_off   (dev_off),
    .dev_dword (dev_dword),
    .dev_we    (dev_we),
    .dev_wdata (dev_wdata)
);

// File: tb/blkmap_router_tb.sv
`timescale 1ns/1ps
module blkmap_router_tb;

    localparam int          NS  = 4;
    localparam logic [31:0] RAM = 32'h0100_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic              cfg_valid = 1'b0;
    logic [1:0]        cfg_slot  = '0;
    logic [31:0]       cfg_base  = '0;
    logic [31:0]       cfg_size  = '0;
    logic              cfg_wide  = 1'b0;
    logic              req_valid = 1'b0;
    logic [31:0]       req_addr  = '0;
    logic              req_dword = 1'b0;
    logic              req_write = 1'b0;
    logic [31:0]       req_wdata = '0;
    logic              req_ready;
    logic [31:0]       req_rdata;
    logic              ram_en, ram_dword, ram_we;
    logic [31:0]       ram_addr, ram_wdata, ram_rdata;
    logic [NS-1:0]     dev_en;
    logic [31:0]       dev_off, dev_wdata;
    logic              dev_dword, dev_we;
    logic [NS-1:0][31:0] dev_rdata;

    int checks = 0;
    int errors = 0;

    blkmap_router #(.NUM_SLOTS(NS), .BLK_SHIFT(14), .RAM_BYTES(RAM)) u_dut (
        .clk(clk), .rst(rst),
        .cfg_valid(cfg_valid), .cfg_slot(cfg_slot), .cfg_base(cfg_base),
        .cfg_size(cfg_size), .cfg_wide(cfg_wide),
        .req_valid(req_valid), .req_addr(req_addr), .req_dword(req_dword),
        .req_write(req_write), .req_wdata(req_wdata),
        .req_ready(req_ready), .req_rdata(req_rdata),
        .ram_en(ram_en), .ram_addr(ram_addr), .ram_dword(ram_dword),
        .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .dev_en(dev_en), .dev_off(dev_off), .dev_dword(dev_dword),
        .dev_we(dev_we), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
    );

    // Responders: read data is a fixed function of source and address.
    function automatic logic [31:0] patt(input int k, input logic [31:0] a);
        return (a * 32'h0101_0111) ^ (32'(k + 1) * 32'h2468_ACE1);
    endfunction

    always_comb begin
        ram_rdata = patt(7, ram_addr);
        for (int s = 0; s < NS; s++) dev_rdata[s] = patt(s, dev_off);
    end

    // Behavioural registration model: age stamps, newest stamp wins.
    logic [31:0] m_base [NS];
    logic [31:0] m_size [NS];
    bit          m_live [NS];
    bit          m_wide [NS];
    int          m_stamp[NS];
    int          stamp_ctr = 0;

    task automatic model_reset();
        for (int s = 0; s < NS; s++) begin
            m_live[s] = 0; m_wide[s] = 0; m_base[s] = 0; m_size[s] = 0; m_stamp[s] = 0;
        end
    endtask

    task automatic model_route(input logic [31:0] a, output int kind, output int slot,
                               output logic [31:0] off, output bit wide);
        int best;
        best = -1; kind = 0; slot = 0; off = a; wide = 1;
        for (int s = 0; s < NS; s++) begin
            logic [63:0] lo, hi, aa;
            lo = {32'h0, m_base[s]};
            hi = lo + {32'h0, m_size[s]};
            aa = {32'h0, a};
            if (m_live[s] && aa >= lo && aa < hi && m_stamp[s] > best) begin
                best = m_stamp[s]; slot = s;
            end
        end
        if (best >= 0) begin
            kind = 1; off = a - m_base[slot]; wide = m_wide[slot];
        end else if (a < RAM) begin
            kind = 0; off = a; wide = 1;
        end else begin
            kind = 2; off = a - RAM; wide = 0;
        end
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic do_cfg(input int slot, input logic [31:0] base, input logic [31:0] size,
                          input bit wide, input string tag);
        logic [63:0] lim;
        cfg_valid = 1'b1; cfg_slot = 2'(slot); cfg_base = base; cfg_size = size; cfg_wide = wide;
        @(negedge clk);
        cfg_valid = 1'b0;
        chk(!ram_en && dev_en == '0 && !req_ready, tag, "quiet during config",
            {59'h0, ram_en, dev_en}, 64'h0);
        lim = {32'h0, base} + {32'h0, size};
        if (base[13:0] == 0 && size[13:0] == 0 && size != 0 && lim <= 64'h1_0000_0000 && slot < NS) begin
            stamp_ctr++;
            m_live[slot] = 1; m_wide[slot] = wide; m_base[slot] = base;
            m_size[slot] = size; m_stamp[slot] = stamp_ctr;
        end
    endtask

    task automatic do_req(input logic [31:0] a, input bit dw, input bit wr,
                          input logic [31:0] wd, input string tag);
        int kind, slot, nb;
        logic [31:0] off, src, exp_rd, ea, ew;
        bit wide, edw, ok;
        logic [63:0] act, exp;
        model_route(a, kind, slot, off, wide);
        edw = dw && wide;
        nb = (!dw || wide) ? 1 : 4;
        exp_rd = '0;
        req_valid = 1'b1; req_addr = a; req_dword = dw; req_write = wr; req_wdata = wd;
        for (int b = 0; b < nb; b++) begin
            @(negedge clk);
            ea = off + 32'(b);
            ew = edw ? wd : {24'h0, wd[8*b +: 8]};
            case (kind)
                0: src = patt(7, ea);
                1: src = patt(slot, ea);
                default: src = 32'hFFFF_FFFF;
            endcase
            if (edw) exp_rd = src;
            else     exp_rd[8*b +: 8] = src[7:0];
            case (kind)
                0: ok = ram_en && dev_en == '0 && ram_addr == ea && ram_dword == edw
                        && ram_we == wr && (!wr || ram_wdata == ew);
                1: ok = !ram_en && dev_en == NS'(1 << slot) && dev_off == ea && dev_dword == edw
                        && dev_we == wr && (!wr || dev_wdata == ew);
                default: ok = !ram_en && dev_en == '0;
            endcase
            ok = ok && !req_ready;
            act = {4'(dev_en), 3'b0, ram_en, 24'h0, (ram_en ? ram_addr : dev_off)};
            exp = {4'(kind == 1 ? (1 << slot) : 0), 3'b0, (kind == 0), 24'h0, (kind == 2 ? 32'h0 : ea)};
            if (kind == 2) begin
                act[31:0] = 32'h0;
            end
            chk(ok, tag, $sformatf("beat %0d strobe/addr/width/data", b), act, exp);
        end
        @(negedge clk);
        chk(req_ready == 1'b1, tag, "ready pulse (R10)", {63'h0, req_ready}, 64'h1);
        if (!wr) chk(req_rdata == exp_rd, tag, "read data", {32'h0, req_rdata}, {32'h0, exp_rd});
        req_valid = 1'b0;
        @(negedge clk);
        chk(!req_ready && !ram_en && dev_en == '0, tag, "ready low after pulse (R10)",
            {58'h0, req_ready, ram_en, dev_en}, 64'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R12: quiet outputs while in reset
        chk(!req_ready && !ram_en && dev_en == '0, "R12", "reset outputs",
            {58'h0, req_ready, ram_en, dev_en}, 64'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(!req_ready && !ram_en && dev_en == '0, "R12", "after reset release",
            {58'h0, req_ready, ram_en, dev_en}, 64'h0);
        // R12: nothing registered, high space is unmapped
        do_req(32'hE000_0000, 1, 0, 0, "R12");

        // R4: RAM pass-through
        do_req(32'h0000_1234, 1, 0, 0, "R4");
        do_req(32'h0000_1235, 1, 1, 32'hCAFE_F00D, "R4");
        do_req(32'h00FF_FFFC, 1, 0, 0, "R4");
        // R9: byte access to RAM
        do_req(32'h0000_4001, 0, 1, 32'h1234_56A7, "R9");
        do_req(32'h0000_4002, 0, 0, 0, "R9");

        // R5: unmapped region
        do_req(RAM, 0, 0, 0, "R5");
        do_req(32'h2000_0000, 1, 0, 0, "R5");
        do_req(32'h2000_0004, 1, 1, 32'h1111_2222, "R5");

        // R6 / R2: dword-capable region high in space
        do_cfg(0, 32'hE000_0000, 32'h0010_0000, 1, "R6");
        do_req(32'hE000_0104, 1, 0, 0, "R6");
        do_req(32'hE00F_FFFC, 1, 1, 32'hA1B2_C3D4, "R2");
        do_req(32'hE010_0000, 1, 0, 0, "R5");

        // R7 / R8: byte-only region inside RAM range
        do_cfg(1, 32'h000A_0000, 32'h0002_0000, 0, "R7");
        do_req(32'h000A_1002, 1, 0, 0, "R7");
        do_req(32'h000B_FFF0, 1, 1, 32'h8899_AABB, "R8");
        do_req(32'h000A_0003, 0, 0, 0, "R9");
        do_req(32'h0009_FFFC, 1, 0, 0, "R4");

        // R3: overlap, newest wins; re-registering takes precedence back
        do_cfg(2, 32'hE000_0000, 32'h0000_4000, 0, "R3");
        do_req(32'hE000_0010, 1, 0, 0, "R3");
        do_req(32'hE000_4000, 1, 0, 0, "R3");
        do_cfg(0, 32'hE000_0000, 32'h0010_0000, 1, "R3");
        do_req(32'hE000_0010, 1, 0, 0, "R3");
        do_cfg(1, 32'h3000_0000, 32'h0000_8000, 0, "R3");
        do_req(32'h000A_1000, 1, 0, 0, "R3");
        do_req(32'h3000_7FFC, 1, 0, 0, "R3");

        // R1: malformed registrations change nothing
        do_cfg(3, 32'h1000_2000, 32'h0000_4000, 1, "R1");
        do_cfg(3, 32'h1000_0000, 32'h0000_0000, 1, "R1");
        do_cfg(3, 32'h1000_0000, 32'h0000_5000, 1, "R1");
        do_cfg(3, 32'hFFFF_C000, 32'h0000_8000, 1, "R1");
        do_req(32'h1000_0000, 1, 0, 0, "R1");
        do_req(32'h1000_2000, 0, 0, 0, "R1");
        do_req(32'hFFFF_C000, 1, 0, 0, "R1");
        do_cfg(3, 32'hFFFF_C000, 32'h0000_4000, 1, "R1");
        do_req(32'hFFFF_FFFC, 1, 0, 0, "R1");

        // R2 / R11: random traffic over the resulting map
        for (int i = 0; i < 40; i++) begin
            logic [31:0] bases [6];
            logic [31:0] a;
            bases[0] = 32'h0000_2000; bases[1] = 32'hE000_0000; bases[2] = 32'h3000_0000;
            bases[3] = 32'hFFFF_C000; bases[4] = 32'h4000_0000; bases[5] = 32'h000A_0000;
            a = bases[$urandom % 6] + ($urandom % 32'h0FF0);
            do_req(a, 1'($urandom), 1'($urandom), $urandom, "R11");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule